// File: doc/BRIEF.md
# Eight-bit up/down timer with compare and waveform output

This block is an 8-bit counter with one compare channel and one waveform output pin. A clock-select stage turns a per-cycle enable into a timer tick. The enable is either off, a prescaled system-clock strobe, or an external-oscillator strobe that has already been synchronised. On every tick the counter takes one step, up or down. It moves between BOTTOM (0x00) and a TOP value. TOP is 0xFF in three modes. In clear-on-match mode TOP is the active compare value. The active compare value is fed from a write buffer. In the PWM modes the buffer is copied over only at the top of the count, so a new duty cycle never produces a glitch. In the other modes a write takes effect at once.

The counter direction is a two-state machine. In state `UP` the next tick increments the count. In state `DOWN` the next tick decrements it. The transition `UP->DOWN` is taken on the tick that makes the count 0xFF in phase-correct mode, or on a tick at 0xFF while still in `UP`. The transition `DOWN->UP` is taken on the tick that brings the count to 0x00, or on a tick at 0x00. In every other mode the machine is forced back to `UP`. A compare hit sets a sticky compare flag and steers the output pin. Overflow sets a sticky overflow flag. Both flags are cleared by writing one to them. A small register bus reads and writes the control, count, compare and flag registers.

Top module: `octet_timer`

## Requirements
- R1: After reset, control, count, compare buffer and flags all read 0x00 and `wave_out` is 0.
- R2: With the run bit (control bit 0) clear, the count, flags and output do not change, whatever the tick inputs do.
- R3: Control bit 1 selects the tick source: 0 takes `presc_tick` and 1 takes `ext_tick`. The unselected strobe has no effect on the count.
- R4: Normal mode (control bits 3:2 = 00) counts up by one per tick and wraps from 0xFF to 0x00. The wrap tick sets the overflow flag (flag bit 1).
- R5: Clear-on-match mode (10): a tick with the count equal to the active compare value returns the count to 0x00.
- R6: Phase-correct mode (01) counts up to 0xFF and then down: 0xFE, 0xFF, 0xFE. The tick that brings the count down to 0x00 sets the overflow flag, and the following tick gives 0x01.
- R7: Fast PWM mode (11): the wrap tick at 0xFF drives `wave_out` high, and a compare hit drives it low. When both happen on the same tick, high wins, so a compare value of 0xFF keeps the output high.
- R8: In the PWM modes, a compare write only loads the buffer (address 2 reads it back). The active value takes the buffer on a tick at count 0xFF. In normal and clear-on-match modes, the write loads the active value at once.
- R9: A write to the count register (address 1) suppresses any compare hit on the next tick.
- R10: A write of one to a flag bit (address 3: bit 0 compare, bit 1 overflow) clears that flag. A zero leaves it as it is. A set of the flag in the same cycle wins over the clear.
- R11: In normal and clear-on-match modes, each compare hit toggles `wave_out` and sets the compare flag.
- R12: In phase-correct mode, a hit while in state `UP` drives `wave_out` low, and a hit while in state `DOWN` drives it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 count, 2 compare, 3 flags |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| presc_tick | input | 1 | Prescaled system-clock strobe |
| ext_tick | input | 1 | Synchronised external-oscillator strobe |
| wave_out | output | 1 | Waveform output pin |
| cmp_flag | output | 1 | Sticky compare-match flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
If the direction state is wrong, the count goes the wrong way on the very next tick, and a single count read shows it. This is why the bench reads the count right around 0xFF and 0x00 in phase-correct mode. If the active compare value is stale or updated too early, the waveform edge and the compare flag move to another tick. This shows within one period, at the edge the bench expects. A blocking register that is missing or stuck would, in the same tick, either raise a flag or leave a hit out.

// File: rtl/octt_pkg.sv
package octt_pkg;
    typedef enum logic [1:0] {
        MD_NORMAL   = 2'b00,
        MD_PHASE    = 2'b01,
        MD_CLRMATCH = 2'b10,
        MD_FAST     = 2'b11
    } mode_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_COUNT = 2'd1;
    localparam logic [ADDR_W-1:0] A_CMP   = 2'd2;
    localparam logic [ADDR_W-1:0] A_FLAGS = 2'd3;
endpackage

// File: rtl/octt_clksel.sv
module octt_clksel (
    input  logic run,
    input  logic ext_sel,
    input  logic presc_tick,
    input  logic ext_tick,
    output logic tick
);
    always_comb begin
        tick = run & (ext_sel ? ext_tick : presc_tick);
    end
endmodule

// File: rtl/octt_counter.sv
module octt_counter
    import octt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  mode_e        mode,
    input  logic [W-1:0] clr_top,
    output logic [W-1:0] cnt,
    output dir_e         dir,
    output logic         ovf_evt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] BOTV = '0;
    localparam logic [W-1:0] ONEV = {{(W-1){1'b0}}, 1'b1};

    dir_e         dir_nxt;
    logic [W-1:0] cnt_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir <= DIR_UP;
            cnt <= BOTV;
        end else begin
            dir <= dir_nxt;
            cnt <= cnt_nxt;
        end
    end

    always_comb begin
        dir_nxt = dir;
        cnt_nxt = cnt;
        ovf_evt = 1'b0;
        if (load) begin
            cnt_nxt = load_val;
            if (mode != MD_PHASE) dir_nxt = DIR_UP;
        end else if (tick) begin
            if (mode != MD_PHASE) begin
                dir_nxt = DIR_UP;
                if (cnt == MAXV) begin
                    cnt_nxt = BOTV;
                    ovf_evt = 1'b1;
                end else if (mode == MD_CLRMATCH && cnt == clr_top) begin
                    cnt_nxt = BOTV;
                end else begin
                    cnt_nxt = cnt + ONEV;
                end
            end else begin
                unique case (dir)
                    DIR_UP: begin
                        if (cnt == MAXV) begin
                            cnt_nxt = MAXV - ONEV;
                            dir_nxt = DIR_DOWN;
                        end else begin
                            cnt_nxt = cnt + ONEV;
                            if (cnt == MAXV - ONEV) dir_nxt = DIR_DOWN;
                        end
                    end
                    DIR_DOWN: begin
                        if (cnt == BOTV) begin
                            cnt_nxt = ONEV;
                            dir_nxt = DIR_UP;
                        end else begin
                            cnt_nxt = cnt - ONEV;
                            if (cnt == ONEV) begin
                                dir_nxt = DIR_UP;
                                ovf_evt = 1'b1;
                            end
                        end
                    end
                endcase
            end
        end
    end

    assert_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt));

    assert_pc_turn_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_PHASE && tick && !load && dir == DIR_UP && cnt == MAXV - ONEV)
        |=> (cnt == MAXV && dir == DIR_DOWN));
endmodule

// File: rtl/octt_compare.sv
module octt_compare
    import octt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic         cmp_wr,
    input  logic [W-1:0] wdata,
    input  mode_e        mode,
    input  logic [W-1:0] cnt,
    input  dir_e         dir,
    output logic [W-1:0] act_val,
    output logic [W-1:0] buf_val,
    output logic         hit,
    output logic         wave
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic pwm;
    logic blk;
    logic top_tick;
    logic wave_nxt;

    always_comb begin
        pwm      = (mode == MD_FAST) || (mode == MD_PHASE);
        top_tick = tick && !load && (cnt == MAXV);
        hit      = tick && !load && !blk && (cnt == act_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_val <= '0;
            act_val <= '0;
            blk     <= 1'b0;
            wave    <= 1'b0;
        end else begin
            if (cmp_wr) buf_val <= wdata;
            if (cmp_wr && !pwm) act_val <= wdata;
            else if (pwm && top_tick) act_val <= buf_val;
            if (load) blk <= 1'b1;
            else if (tick) blk <= 1'b0;
            wave <= wave_nxt;
        end
    end

    always_comb begin
        wave_nxt = wave;
        unique case (mode)
            MD_NORMAL, MD_CLRMATCH: begin
                if (hit) wave_nxt = ~wave;
            end
            MD_FAST: begin
                if (top_tick) wave_nxt = 1'b1;
                else if (hit) wave_nxt = 1'b0;
            end
            MD_PHASE: begin
                if (hit) wave_nxt = (dir == DIR_DOWN);
            end
        endcase
    end

    assert_load_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !hit);

    assert_buf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !top_tick) |=> $stable(act_val));

    assert_fast_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_FAST && top_tick) |=> wave);
endmodule

// File: rtl/octet_timer.sv
module octet_timer
    import octt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic              presc_tick,
    input  logic              ext_tick,
    output logic              wave_out,
    output logic              cmp_flag,
    output logic              ovf_flag
);
    localparam int CTRL_BITS = 4;

    logic         run_q;
    logic         ext_q;
    mode_e        mode_q;
    logic         tick_w;
    logic         wr_ctrl, wr_cnt, wr_cmp, wr_flg;
    logic [W-1:0] cnt_w, act_w, buf_w;
    dir_e         dir_w;
    logic         ovf_evt_w, hit_w, wave_w;

    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == A_CTRL);
        wr_cnt  = bus_wr && (bus_addr == A_COUNT);
        wr_cmp  = bus_wr && (bus_addr == A_CMP);
        wr_flg  = bus_wr && (bus_addr == A_FLAGS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            ext_q  <= 1'b0;
            mode_q <= MD_NORMAL;
        end else if (wr_ctrl) begin
            run_q  <= bus_wdata[0];
            ext_q  <= bus_wdata[1];
            mode_q <= mode_e'(bus_wdata[3:2]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            if (hit_w) cmp_flag <= 1'b1;
            else if (wr_flg && bus_wdata[0]) cmp_flag <= 1'b0;
            if (ovf_evt_w) ovf_flag <= 1'b1;
            else if (wr_flg && bus_wdata[1]) ovf_flag <= 1'b0;
        end
    end

    octt_clksel u_clksel (
        .run        (run_q),
        .ext_sel    (ext_q),
        .presc_tick (presc_tick),
        .ext_tick   (ext_tick),
        .tick       (tick_w)
    );

    octt_counter #(.W(W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_w),
        .load     (wr_cnt),
        .load_val (bus_wdata),
        .mode     (mode_q),
        .clr_top  (act_w),
        .cnt      (cnt_w),
        .dir      (dir_w),
        .ovf_evt  (ovf_evt_w)
    );

    octt_compare #(.W(W)) u_compare (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_w),
        .load    (wr_cnt),
        .cmp_wr  (wr_cmp),
        .wdata   (bus_wdata),
        .mode    (mode_q),
        .cnt     (cnt_w),
        .dir     (dir_w),
        .act_val (act_w),
        .buf_val (buf_w),
        .hit     (hit_w),
        .wave    (wave_w)
    );

    always_comb begin
        wave_out  = wave_w;
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:  bus_rdata[CTRL_BITS-1:0] = {mode_q, ext_q, run_q};
            A_COUNT: bus_rdata = cnt_w;
            A_CMP:   bus_rdata = buf_w;
            A_FLAGS: bus_rdata[1:0] = {ovf_flag, cmp_flag};
        endcase
    end

    assert_ovf_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(tick_w));

    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flg && bus_wdata[1] && !ovf_evt_w) |=> !ovf_flag);
endmodule

// File: tb/tb_octet_timer.sv
module tb_octet_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       presc_tick = 1'b0;
    logic       ext_tick = 1'b0;
    logic       wave_out, cmp_flag, ovf_flag;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        string      req;
        int         sel;
        logic [7:0] exp;
    } sb_item_t;
    sb_item_t sbq[$];
    sb_item_t cur;
    logic [7:0] act;

    always #5 clk = ~clk;

    octet_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .presc_tick(presc_tick),
        .ext_tick(ext_tick), .wave_out(wave_out), .cmp_flag(cmp_flag),
        .ovf_flag(ovf_flag)
    );

    // Monitor: pops expected items and compares them with the ports.
    always @(negedge clk) begin
        #2;
        while (sbq.size() > 0) begin
            cur = sbq.pop_front();
            case (cur.sel)
                0: act = bus_rdata;
                1: act = {7'd0, wave_out};
                2: act = {7'd0, cmp_flag};
                default: act = {7'd0, ovf_flag};
            endcase
            n_vec++;
            if (act !== cur.exp) begin
                n_bad++;
                $display("FAIL %s actual=%02h expected=%02h", cur.req, act, cur.exp);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic step(input int n);
        @(negedge clk);
        presc_tick = 1'b1;
        repeat (n) @(negedge clk);
        presc_tick = 1'b0;
    endtask

    task automatic ext_step(input int n);
        @(negedge clk);
        ext_tick = 1'b1;
        repeat (n) @(negedge clk);
        ext_tick = 1'b0;
    endtask

    task automatic rdchk(input logic [1:0] a, input logic [7:0] e, input string req);
        sb_item_t it;
        @(negedge clk);
        bus_addr = a;
        it.req = req; it.sel = 0; it.exp = e;
        sbq.push_back(it);
    endtask

    task automatic pchk(input int s, input logic [7:0] e, input string req);
        sb_item_t it;
        @(negedge clk);
        it.req = req; it.sel = s; it.exp = e;
        sbq.push_back(it);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rdchk(2'd0, 8'h00, "R1 ctrl");
        rdchk(2'd1, 8'h00, "R1 count");
        rdchk(2'd2, 8'h00, "R1 compare");
        rdchk(2'd3, 8'h00, "R1 flags");
        pchk(1, 8'h00, "R1 wave");
        // R2 frozen with no source
        step(5);
        rdchk(2'd1, 8'h00, "R2 count frozen");
        rdchk(2'd3, 8'h00, "R2 no flags");
        // R3 source select, R4 normal counting
        wr(2'd2, 8'h80);
        wr(2'd0, 8'h01);
        step(3);
        rdchk(2'd1, 8'h03, "R3 prescaled source");
        wr(2'd0, 8'h03);
        step(4);
        rdchk(2'd1, 8'h03, "R3 presc ignored when ext selected");
        ext_step(2);
        rdchk(2'd1, 8'h05, "R3 external source");
        wr(2'd0, 8'h01);
        wr(2'd1, 8'hFE);
        step(1);
        rdchk(2'd3, 8'h00, "R4 no overflow before wrap");
        step(1);
        rdchk(2'd1, 8'h00, "R4 wrap to zero");
        rdchk(2'd3, 8'h02, "R4 overflow flag");
        // R10 write-one-to-clear
        wr(2'd3, 8'h01);
        rdchk(2'd3, 8'h02, "R10 zero leaves overflow");
        wr(2'd3, 8'h02);
        rdchk(2'd3, 8'h00, "R10 one clears overflow");
        // R11 normal toggle
        wr(2'd1, 8'h7E);
        step(2);
        pchk(1, 8'h00, "R11 no toggle before hit");
        step(1);
        pchk(1, 8'h01, "R11 toggle on hit");
        rdchk(2'd3, 8'h01, "R11 compare flag");
        wr(2'd3, 8'h01);
        // R9 count write blocks hit
        wr(2'd1, 8'h80);
        step(1);
        rdchk(2'd3, 8'h00, "R9 hit blocked");
        pchk(1, 8'h01, "R9 wave unchanged");
        // R5 clear-on-match
        wr(2'd0, 8'h09);
        wr(2'd2, 8'h05);
        wr(2'd1, 8'h03);
        step(3);
        rdchk(2'd1, 8'h00, "R5 cleared at TOP");
        rdchk(2'd3, 8'h01, "R5 compare flag");
        pchk(1, 8'h00, "R11 toggle in clear-on-match");
        wr(2'd3, 8'h01);
        // R8 double buffer in fast PWM
        wr(2'd0, 8'h0D);
        wr(2'd2, 8'h40);
        rdchk(2'd2, 8'h40, "R8 buffer readback");
        wr(2'd1, 8'h04);
        step(2);
        rdchk(2'd3, 8'h01, "R8 old active value still matches");
        wr(2'd1, 8'hFE);
        step(2);
        pchk(1, 8'h01, "R7 high after wrap");
        rdchk(2'd3, 8'h03, "R4 overflow in fast mode");
        wr(2'd3, 8'h03);
        wr(2'd1, 8'h3E);
        step(3);
        pchk(1, 8'h00, "R7 low on hit");
        rdchk(2'd3, 8'h01, "R8 new active value after TOP");
        wr(2'd3, 8'h01);
        // R7 compare at 0xFF keeps output high
        wr(2'd2, 8'hFF);
        wr(2'd1, 8'hFE);
        step(2);
        wr(2'd1, 8'hFE);
        step(2);
        pchk(1, 8'h01, "R7 set wins over hit");
        rdchk(2'd3, 8'h03, "R7 hit at 0xFF flagged");
        // R6 phase-correct
        wr(2'd0, 8'h05);
        wr(2'd2, 8'h10);
        wr(2'd3, 8'h03);
        wr(2'd1, 8'hFD);
        step(2);
        rdchk(2'd1, 8'hFF, "R6 reaches 0xFF");
        step(1);
        rdchk(2'd1, 8'hFE, "R6 turns down");
        wr(2'd1, 8'h02);
        step(2);
        rdchk(2'd1, 8'h00, "R6 reaches BOTTOM");
        rdchk(2'd3, 8'h03, "R6 overflow at BOTTOM");
        step(1);
        rdchk(2'd1, 8'h01, "R6 turns up");
        wr(2'd3, 8'h03);
        // R12 phase-correct output
        wr(2'd1, 8'h0E);
        step(3);
        pchk(1, 8'h00, "R12 low on up hit");
        wr(2'd1, 8'hFE);
        step(2);
        wr(2'd1, 8'h11);
        step(2);
        pchk(1, 8'h01, "R12 high on down hit");
        rdchk(2'd1, 8'h0F, "R12 count going down");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule